// File: doc/BRIEF.md
# Instruction Fetch Next-Address Unit

This block holds the program counter of a single-cycle processor and works out, every clock, where the next instruction will be fetched from. The counter is kept as a word address. Each instruction is one 32-bit word, so the two low bits of a byte address are always zero and do not need to be stored. The byte address sent to instruction memory is the stored word address with two zero bits appended.

Each cycle the decoder gives the unit three control inputs (branch request, the equality flag from the ALU, and jump request) and two instruction fields: the 16-bit signed offset and the 26-bit jump target. Without a jump or a taken branch, the counter moves to the next word. On a taken branch, the offset, counted in words, is added to the next-word address. On a jump, the low bits of the counter are replaced by the target field and the top bits are kept.

A parameter picks one of two adder arrangements. One is a single adder with its carry-in tied high, which is small but has to wait for the branch decision. The other is two adders that work in parallel, followed by a multiplexer, which is larger but faster.

Top module: `nxa_fetch_unit`

## Requirements
- R1: `fetch_addr_o` equals the stored 30-bit word counter followed by two zero bits, so bits [1:0] are always 0.
- R2: When `jump_i` is 0 and the branch is not taken, the counter advances by exactly 1 at the rising clock edge.
- R3: When `branch_i` and `zero_i` are both 1 and `jump_i` is 0, the next counter is counter + 1 + the 16-bit offset `imm_i`, sign-extended to 30 bits.
- R4: A branch is taken only when both `branch_i` and `zero_i` are 1. If `branch_i`=1 with `zero_i`=0, or `branch_i`=0 with `zero_i`=1, the offset has no effect and the counter advances by 1.
- R5: When `jump_i` is 1, the next counter is the top 4 bits of the current counter concatenated with `target_i` (26 bits).
- R6: Both adder arrangements give identical next addresses for identical inputs. `FAST_NPC`=1 builds two parallel adders and a multiplexer. `FAST_NPC`=0 builds one adder with carry-in 1 whose second operand is the offset or zero.
- R7: When `jump_i` and a taken branch are asserted together, the jump wins.
- R8: Driving `rst_ni` low loads `RESET_PC` into the counter at once, without waiting for a clock edge. Outside reset, the counter changes only on the rising edge of `clk_i`.
- R9: Counter arithmetic wraps modulo 2^30. Advancing from 30'h3FFFFFFF gives 0, and a negative offset can move the counter below 0, wrapping to the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the counter updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imm_i | input | 16 | Signed branch offset in words |
| target_i | input | 26 | Jump target word field |
| branch_i | input | 1 | Current instruction is a conditional branch |
| zero_i | input | 1 | Equality flag from the ALU |
| jump_i | input | 1 | Current instruction is an absolute jump |
| fetch_addr_o | output | 32 | Byte address for instruction memory |

## Verification
The bench builds two copies side by side and drives them with the same stimulus. The first uses the two-adder arrangement and starts from 0. The second uses the single carry-in adder and starts from 30'h3FFFFFFE, so the wrap at the top of the word space is reached after two sequential steps. A branch with a negative offset taken from address 0 wraps the first copy downward, which moves its top four bits to all ones. A jump from there then shows that those top bits are kept, something that cannot be observed while the counter stays near zero.

// File: rtl/nxa_pkg.sv
package nxa_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2
  } npc_src_e;
endpackage

// File: rtl/nxa_sel_ctrl.sv
module nxa_sel_ctrl
  import nxa_pkg::*;
(
  input  logic     branch_i,
  input  logic     zero_i,
  input  logic     jump_i,
  output npc_src_e src_o,
  output logic     taken_o
);
  always_comb begin
    taken_o = branch_i & zero_i;
    if (jump_i)       src_o = SRC_JUMP;   // jump outranks branch
    else if (taken_o) src_o = SRC_BRANCH;
    else              src_o = SRC_SEQ;
  end
endmodule

// File: rtl/nxa_offset_add.sv
module nxa_offset_add #(
  parameter int unsigned PC_W     = 30,
  parameter int unsigned IMM_W    = 16,
  parameter bit          FAST_NPC = 1'b1
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             taken_i,
  output logic [PC_W-1:0]  next_o
);
  localparam int unsigned EXT_W = PC_W - IMM_W;
  localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

  logic [PC_W-1:0] offset;
  assign offset = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  generate
    if (FAST_NPC) begin : g_fast
      logic [PC_W-1:0] seq_sum, br_sum;
      assign seq_sum = pc_i + ONE;
      assign br_sum  = pc_i + offset + ONE;
      assign next_o  = taken_i ? br_sum : seq_sum;
    end else begin : g_cheap
      logic [PC_W-1:0] opnd;
      assign opnd   = taken_i ? offset : '0;
      assign next_o = pc_i + opnd + ONE;  // carry-in of 1
    end
  endgenerate
endmodule

// File: rtl/nxa_pc_reg.sv
module nxa_pc_reg #(
  parameter int unsigned       PC_W     = 30,
  parameter logic [PC_W-1:0]   RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] d_i,
  output logic [PC_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RESET_PC;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/nxa_fetch_unit.sv
module nxa_fetch_unit
  import nxa_pkg::*;
#(
  parameter int unsigned     PC_W     = 30,
  parameter int unsigned     IMM_W    = 16,
  parameter int unsigned     TGT_W    = 26,
  parameter bit              FAST_NPC = 1'b1,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [TGT_W-1:0] target_i,
  input  logic             branch_i,
  input  logic             zero_i,
  input  logic             jump_i,
  output logic [PC_W+1:0]  fetch_addr_o
);
  localparam int unsigned HI_W = PC_W - TGT_W;

  npc_src_e        src;
  logic            taken;
  logic [PC_W-1:0] pc_q, add_res, jump_pc, pc_d;

  nxa_sel_ctrl i_sel (
    .branch_i(branch_i), .zero_i(zero_i), .jump_i(jump_i),
    .src_o(src), .taken_o(taken)
  );

  nxa_offset_add #(.PC_W(PC_W), .IMM_W(IMM_W), .FAST_NPC(FAST_NPC)) i_add (
    .pc_i(pc_q), .imm_i(imm_i), .taken_i(taken), .next_o(add_res)
  );

  assign jump_pc = {pc_q[PC_W-1 -: HI_W], target_i};
  assign pc_d    = (src == SRC_JUMP) ? jump_pc : add_res;

  nxa_pc_reg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) i_pc (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pc_d), .q_o(pc_q)
  );

  assign fetch_addr_o = {pc_q, 2'b00};

  assert_seq_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jump_i && !branch_i) |=> pc_q == $past(pc_q) + 1'b1);

  assert_branch_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jump_i && branch_i && zero_i) |=>
      pc_q == $past(pc_q) + 1'b1 + {{(PC_W-IMM_W){$past(imm_i[IMM_W-1])}}, $past(imm_i)});

  assert_branch_untaken_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jump_i && branch_i && !zero_i) |=> pc_q == $past(pc_q) + 1'b1);

  assert_jump_target_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_i |=> pc_q[TGT_W-1:0] == $past(target_i) &&
               pc_q[PC_W-1:TGT_W] == $past(pc_q[PC_W-1:TGT_W]));

  assert_jump_priority_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && branch_i && zero_i) |=> pc_q[TGT_W-1:0] == $past(target_i));
endmodule

// File: tb/test_nxa_fetch_unit.sv
module test_nxa_fetch_unit;
  localparam logic [29:0] RST_B = 30'h3FFF_FFFE;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] imm_i = '0;
  logic [25:0] target_i = '0;
  logic        branch_i = 1'b0, zero_i = 1'b0, jump_i = 1'b0;
  logic [31:0] addr_a, addr_b;
  logic [29:0] exp_a, exp_b;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  nxa_fetch_unit #(.FAST_NPC(1'b1), .RESET_PC(30'h0)) i_nxa_fetch_unit (
    .clk_i, .rst_ni, .imm_i, .target_i, .branch_i, .zero_i, .jump_i,
    .fetch_addr_o(addr_a));

  nxa_fetch_unit #(.FAST_NPC(1'b0), .RESET_PC(RST_B)) i_nxa_fetch_unit_slow (
    .clk_i, .rst_ni, .imm_i, .target_i, .branch_i, .zero_i, .jump_i,
    .fetch_addr_o(addr_b));

  function automatic logic [29:0] model(logic [29:0] pc, logic [15:0] imm,
                                        logic [25:0] tgt, logic br, logic z, logic j);
    if (j)            return {pc[29:26], tgt};
    else if (br && z) return pc + 30'd1 + {{14{imm[15]}}, imm};
    else              return pc + 30'd1;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step(string req, logic [15:0] imm, logic [25:0] tgt,
                      logic br, logic z, logic j);
    imm_i = imm; target_i = tgt; branch_i = br; zero_i = z; jump_i = j;
    exp_a = model(exp_a, imm, tgt, br, z, j);
    exp_b = model(exp_b, imm, tgt, br, z, j);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(req, addr_a, {exp_a, 2'b00});
    chk({req, "_R6"}, addr_b, {exp_b, 2'b00});
  endtask

  task automatic t_reset();  // R8, R1
    rst_ni = 1'b0;
    @(negedge clk_i);
    exp_a = 30'h0; exp_b = RST_B;
    chk("R8", addr_a, 32'h0);
    chk("R8", addr_b, {RST_B, 2'b00});
    rst_ni = 1'b1;
  endtask

  task automatic t_sequential();  // R2, R9 on copy b
    step("R2", 16'h0, 26'h0, 1'b0, 1'b0, 1'b0);
    step("R9", 16'h0, 26'h0, 1'b0, 1'b0, 1'b0);
    chk("R9", addr_b, 32'h0);
    step("R2", 16'h0, 26'h0, 1'b0, 1'b0, 1'b0);
    chk("R1", {30'h0, addr_a[1:0]}, 32'h0);
  endtask

  task automatic t_branch();  // R3, R4
    step("R3", 16'h0010, 26'h0, 1'b1, 1'b1, 1'b0);
    step("R3", 16'hFFF8, 26'h0, 1'b1, 1'b1, 1'b0);
    step("R4", 16'h0100, 26'h0, 1'b1, 1'b0, 1'b0);
    step("R4", 16'h0100, 26'h0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_jump();  // R5, R7
    step("R5", 16'h0, 26'h0000_000, 1'b0, 1'b0, 1'b1);
    step("R9", 16'hFFFE, 26'h0, 1'b1, 1'b1, 1'b0);  // 0+1-2 wraps to all ones
    chk("R9", addr_a, 32'hFFFF_FFFC);
    step("R5", 16'h0, 26'h123_4567, 1'b0, 1'b0, 1'b1);
    chk("R5", addr_a, {4'hF, 26'h123_4567, 2'b00});
    step("R7", 16'h0040, 26'h2AA_AAAA, 1'b1, 1'b1, 1'b1);
    step("R2", 16'h7FFF, 26'h3FF_FFFF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_async_reset();  // R8: takes effect between edges
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R8", addr_a, 32'h0);
    chk("R8", addr_b, {RST_B, 2'b00});
    @(negedge clk_i);
    rst_ni = 1'b1;
    exp_a = 30'h0; exp_b = RST_B;
    step("R2", 16'h0, 26'h0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_branch();
    t_jump();
    t_async_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk_i);
        n_bad++;
        $display("FAIL watchdog got=timeout exp=finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule